// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Change Interrupts

This block is an eight-pin general purpose I/O port. Software reaches it through a small register bus that holds four registers: direction, pin level, interrupt enable and control. Pins set as outputs are driven from the level register. Every pin is brought into the clock domain through a two-flop synchronizer. A read of the level register returns the synchronized pin levels. An input pin whose interrupt is enabled raises a level-sensitive, active-high interrupt when its level moves away from a reference. That reference is the level captured at the most recent read of the level register.

A control bit selects one of two clearing modes. In transparent mode, the pending state follows the pin: a pin that returns to its reference level withdraws the interrupt. In latched mode, the first change of an enabled pin freezes the new level into a capture register. The interrupt then stays pending until the level register is read, even if the pin reverts before that read.

Two further control bits each hand one half of the port to a modem-signal function. In that mode the pins of the half are driven from, and sensed into, dedicated modem ports. A self-clearing control bit issues a one-cycle software reset. That pulse returns every register to zero.

Top module: `pio_port`

## Requirements
- R1: After rst_ni is released, reads of the direction, enable and control registers (addresses 0, 2, 3) return 0. pin_oe_o is 0 and irq_o is 0.
- R2: A write to the direction register (address 0) sets pin_oe_o to the written value from the next cycle on. For an output pin in GPIO mode, pin_o carries the matching bit of the level register (address 1).
- R3: When no latched capture is pending, a read of the level register (address 1) returns the pin levels seen through the two-flop synchronizer.
- R4: irq_o rises when an input pin in GPIO mode, with its bit in the enable register (address 2) set to 1, changes level. A change on a pin whose enable bit is 0 leaves irq_o low. irq_o is never high while the enable register is 0.
- R5: In transparent mode (control bit 0 = 0), a pin that returns to its reference level clears irq_o without any register access.
- R6: A read of the level register takes the present levels as the new reference and clears irq_o in the following cycle.
- R7: In latched mode (control bit 0 = 1), irq_o and the captured pin level persist after the pin reverts. A read of the level register returns the captured value for that pin.
- R8: Control bits 7..4 and bit 3 read as 0. Writing 1 to bit 3 asserts soft_rst_o for exactly one cycle, and all registers then read 0.
- R9: Control bit 1 hands pins 7..4, and control bit 2 hands pins 3..0, to the modem function. In each such pin order, bit 3 of the half is RI, bit 2 is CD, bit 1 is DTR and bit 0 is DSR. A modem-mode pin with its direction bit set drives mdm_drv_i. Its synchronized level appears on mdm_sense_o. A modem-mode pin never raises irq_o.
- R10: A pin set as an output never raises irq_o, even when its enable bit is set and its level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a read of address 1 takes a new reference |
| addr_i | input | 2 | Register select: 0 direction, 1 level, 2 enable, 3 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pin_i | input | 8 | Pin levels seen at the pads |
| pin_o | output | 8 | Pin drive values |
| pin_oe_o | output | 8 | Pin output enables, 1 = output |
| irq_o | output | 1 | Change interrupt, level, active high |
| soft_rst_o | output | 1 | One-cycle software reset pulse |
| mdm_hi_en_o | output | 1 | Pins 7..4 are in modem mode |
| mdm_lo_en_o | output | 1 | Pins 3..0 are in modem mode |
| mdm_drv_i | input | 8 | Modem drive values for pins in modem mode |
| mdm_sense_o | output | 8 | Synchronized levels of pins in modem mode, 0 elsewhere |

## Verification
On every cycle, the checker confirms four things. The soft reset is a single pulse and it clears the port. A direction write reaches pin_oe_o. The reserved control bits read as zero. irq_o never rises with all enables clear, and in latched mode it holds until a read or a register write. The directed scenarios are the only check on the rest, which depends on a history of pin activity and reads. That covers an interrupt withdrawn by a reverting pin in transparent mode, a captured level that outlives the pin in latched mode, and a read that clears the interrupt. It also covers output pins that stay silent and modem-mode pins that are excluded from interrupts.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_W = 8;

  typedef enum logic [1:0] {
    REG_DIR   = 2'd0,
    REG_LEVEL = 2'd1,
    REG_IEN   = 2'd2,
    REG_CTRL  = 2'd3
  } pio_reg_e;

  localparam int unsigned CTL_LATCH  = 0;
  localparam int unsigned CTL_MDM_HI = 1;
  localparam int unsigned CTL_MDM_LO = 2;
  localparam int unsigned CTL_SRST   = 3;
  localparam int unsigned CTL_W      = 3;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      ien_o,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic              srst_o
);
  logic [W-1:0]     dir_q, out_q, ien_q;
  logic [CTL_W-1:0] ctrl_q;
  logic             srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      ctrl_q <= '0;
      srst_q <= 1'b0;
    end else if (srst_q) begin
      // software reset pulse wins over any write in the same cycle
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      ctrl_q <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= 1'b0;
      if (wr_en_i) begin
        unique case (pio_reg_e'(addr_i))
          REG_DIR:   dir_q <= wdata_i;
          REG_LEVEL: out_q <= wdata_i;
          REG_IEN:   ien_q <= wdata_i;
          REG_CTRL: begin
            ctrl_q <= wdata_i[CTL_W-1:0];
            srst_q <= wdata_i[CTL_SRST];
          end
          default: ;
        endcase
      end
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign ien_o  = ien_q;
  assign ctrl_o = ctrl_q;
  assign srst_o = srst_q;
endmodule

// File: rtl/pio_chg.sv
module pio_chg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] armed_i,
  input  logic         latch_i,
  input  logic         take_ref_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] held_o,
  output logic [W-1:0] cap_o
);
  logic [W-1:0] ref_q, pend_q, cap_q;
  logic [W-1:0] diff, fresh;

  assign diff  = (sync_i ^ ref_q) & armed_i;
  assign fresh = diff & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      pend_q <= '0;
      cap_q  <= '0;
    end else if (clr_i) begin
      ref_q  <= '0;
      pend_q <= '0;
      cap_q  <= '0;
    end else begin
      // unarmed pins track the pin so arming never fires on stale history
      ref_q <= take_ref_i ? sync_i : ((ref_q & armed_i) | (sync_i & ~armed_i));
      if (take_ref_i || !latch_i) pend_q <= '0;
      else                        pend_q <= (pend_q | diff) & armed_i;
      if (latch_i && !take_ref_i) cap_q <= (cap_q & ~fresh) | (sync_i & fresh);
    end
  end

  assign held_o = latch_i ? (pend_q & armed_i) : '0;
  assign pend_o = latch_i ? (pend_q & armed_i) : diff;
  assign cap_o  = cap_q;
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned W = PIO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic         irq_o,
  output logic         soft_rst_o,
  output logic         mdm_hi_en_o,
  output logic         mdm_lo_en_o,
  input  logic [W-1:0] mdm_drv_i,
  output logic [W-1:0] mdm_sense_o
);
  localparam int unsigned NIB = W / 2;

  logic [W-1:0]     dir_q, out_q, ien_q, sync_q;
  logic [CTL_W-1:0] ctrl_q;
  logic             srst_q;
  logic [W-1:0]     mdm_mask, armed, pend, held, cap, level_rd;
  logic             take_ref;

  pio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .dir_o(dir_q), .out_o(out_q), .ien_o(ien_q), .ctrl_o(ctrl_q), .srst_o(srst_q)
  );

  pio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_q)
  );

  assign mdm_mask = {{(W-NIB){ctrl_q[CTL_MDM_HI]}}, {NIB{ctrl_q[CTL_MDM_LO]}}};
  assign armed    = ien_q & ~dir_q & ~mdm_mask;
  assign take_ref = rd_en_i && (pio_reg_e'(addr_i) == REG_LEVEL);

  pio_chg #(.W(W)) u_chg (
    .clk_i, .rst_ni, .clr_i(srst_q), .sync_i(sync_q), .armed_i(armed),
    .latch_i(ctrl_q[CTL_LATCH]), .take_ref_i(take_ref),
    .pend_o(pend), .held_o(held), .cap_o(cap)
  );

  assign level_rd = (sync_q & ~held) | (cap & held);

  always_comb begin
    unique case (pio_reg_e'(addr_i))
      REG_DIR:   rdata_o = dir_q;
      REG_LEVEL: rdata_o = level_rd;
      REG_IEN:   rdata_o = ien_q;
      REG_CTRL:  rdata_o = {{(W-CTL_W){1'b0}}, ctrl_q};
      default:   rdata_o = '0;
    endcase
  end

  assign pin_oe_o    = dir_q;
  assign pin_o       = (out_q & ~mdm_mask) | (mdm_drv_i & mdm_mask);
  assign irq_o       = |pend;
  assign soft_rst_o  = srst_q;
  assign mdm_hi_en_o = ctrl_q[CTL_MDM_HI];
  assign mdm_lo_en_o = ctrl_q[CTL_MDM_LO];
  assign mdm_sense_o = sync_q & mdm_mask;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
  import pio_pkg::*;
#(
  parameter int unsigned W = PIO_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic         rd_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] pin_oe_o,
  input logic         irq_o,
  input logic         soft_rst_o,
  input logic [W-1:0] ien_q,
  input logic         latch
);
  p_soft_rst_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  p_soft_rst_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (pin_oe_o == '0) && !irq_o);

  p_ctrl_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CTRL) |-> (rdata_o[W-1:CTL_SRST] == '0));

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR && !soft_rst_o) |=> (pin_oe_o == $past(wdata_i)));

  p_irq_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch && irq_o && !rd_en_i && !wr_en_i && !soft_rst_o) |=> irq_o);
endmodule

bind pio_port pio_port_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_oe_o(pin_oe_o),
  .irq_o(irq_o), .soft_rst_o(soft_rst_o), .ien_q(ien_q), .latch(ctrl_q[0])
);

// File: tb/pio_port_tb.sv
`timescale 1ns/1ps
module pio_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pin_in, pin_out, pin_oe, mdm_drv = '0, mdm_sense;
  logic [7:0] ext = '0;
  logic       irq, srst, mdm_hi, mdm_lo;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  pio_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq), .soft_rst_o(srst), .mdm_hi_en_o(mdm_hi),
    .mdm_lo_en_o(mdm_lo), .mdm_drv_i(mdm_drv), .mdm_sense_o(mdm_sense)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    idle(1);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(2'd0, d); chk("R1 dir", d, 8'h00);
    rd(2'd2, d); chk("R1 ien", d, 8'h00);
    rd(2'd3, d); chk("R1 ctrl", d, 8'h00);
  endtask

  task automatic t_dir_out();
    logic [7:0] d;
    wr(2'd0, 8'hF0);
    wr(2'd1, 8'hA5);
    idle(1);
    chk("R2 oe", pin_oe, 8'hF0);
    chk("R2 pin_o", pin_out & 8'hF0, 8'hA0);
    ext = 8'h0C; idle(4);
    rd(2'd1, d); chk("R3 level read", d, 8'hAC);
  endtask

  task automatic t_transparent();
    logic [7:0] d;
    wr(2'd2, 8'h0F);
    ext = 8'h0D; idle(4);
    chk("R4 irq on change", {7'b0, irq}, 8'h01);
    ext = 8'h0C; idle(4);
    chk("R5 revert withdraws", {7'b0, irq}, 8'h00);
    ext = 8'h0E; idle(4);
    chk("R4 irq again", {7'b0, irq}, 8'h01);
    rd(2'd1, d); chk("R3 level", d, 8'hAE);
    idle(1);
    chk("R6 read clears", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ignored();
    wr(2'd2, 8'h01);
    ext = 8'h0A; idle(4);
    chk("R4 disabled pin ignored", {7'b0, irq}, 8'h00);
    wr(2'd2, 8'hF0);
    wr(2'd1, 8'h50); idle(4);
    chk("R10 output pins silent", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_latched();
    logic [7:0] d;
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h01);
    ext = 8'h0B; idle(4);
    chk("R7 latched irq", {7'b0, irq}, 8'h01);
    ext = 8'h0A; idle(4);
    chk("R7 held after revert", {7'b0, irq}, 8'h01);
    rd(2'd1, d); chk("R7 captured value", d, 8'h5B);
    idle(1);
    chk("R6 latched read clears", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_modem();
    wr(2'd3, 8'h02);
    wr(2'd0, 8'h20);
    wr(2'd2, 8'hD0);
    mdm_drv = 8'hFF; idle(1);
    chk("R9 hi enable", {6'b0, mdm_hi, mdm_lo}, 8'h02);
    chk("R9 DTR drive", {7'b0, pin_out[5]}, 8'h01);
    ext = 8'h8A; idle(4);
    chk("R9 no modem irq", {7'b0, irq}, 8'h00);
    chk("R9 sense", mdm_sense, 8'hA0);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(2'd3, 8'hF5);
    rd(2'd3, d); chk("R8 reserved read 0", d, 8'h05);
    @(negedge clk); wr_en = 1'b1; addr = 2'd3; wdata = 8'h08;
    @(posedge clk); #1 wr_en = 1'b0;
    chk("R8 pulse high", {7'b0, srst}, 8'h01);
    @(posedge clk); #1;
    chk("R8 pulse one cycle", {7'b0, srst}, 8'h00);
    idle(1);
    chk("R8 oe cleared", pin_oe, 8'h00);
    rd(2'd3, d); chk("R8 ctrl cleared", d, 8'h00);
    rd(2'd2, d); chk("R8 ien cleared", d, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir_out();
    t_transparent();
    t_ignored();
    t_latched();
    t_modem();
    t_ctrl();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule